// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a 32-bit local-bus address into a PCI bus address, a PCI cycle type and a prefetch hint. It holds a configurable number of general memory windows (two by default) and one I/O window. Each window has a base register and a map register, loaded through a simple write port. A translation request is answered one clock later with a hit flag, the translated address, the cycle type, the index of the window that answered and that window's prefetch flag.

Windows may overlap. The memory windows are checked in ascending index order, and the I/O window is checked last. The lowest-numbered enabled window that covers the address gives the result. Software can use this to hide one window behind another: it widens a lower window over a higher one, reprograms the higher one, then shrinks the lower one again. An address that no enabled window covers gives a miss.

Register write addresses are `{window_index, is_map}`. For memory window i, the base register is at 2i and the map register is at 2i+1. For the I/O window, the base register is at 2·NUM_MEM_WIN and the map register is at 2·NUM_MEM_WIN+1. Writes to any other address are dropped.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset, every window is disabled, rsp_valid is 0, and any request gives a miss.
- R2: A memory window with base bit 0 set covers an address when address bits 31:(20+s) equal base bits 31:(20+s). Here s is the size code in base bits 7:4, and the window size is 1 MB shifted left by s.
- R3: For a hit in a memory window, translated bits 31:(20+s) come from map bits 15:4, shifted so that map bit 4 lines up with address bit 20. Translated bits (20+s-1):2 equal the request address bits.
- R4: rsp_ctype carries map bits 3:1 of the hitting memory window unchanged. The encodings are 000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration and 110 memory-multiple.
- R5: For a memory-window hit, translated bits 1:0 equal request bits 1:0 when map bit 0 is 1, and are 00 when map bit 0 is 0.
- R6: When several enabled windows cover an address, the one with the lowest index wins. The I/O window, index NUM_MEM_WIN, has the lowest priority.
- R7: The I/O window, enabled by its base bit 0, covers a 16 MB region: the address matches when address bits 31:24 equal I/O base bits 15:8. On a hit, the translated address is {I/O map bits 15:8, request bits 23:0}, rsp_ctype is 001 and rsp_prefetch is 0.
- R8: A request that no enabled window covers returns rsp_valid 1 and rsp_hit 0, with rsp_addr, rsp_ctype, rsp_win and rsp_prefetch all 0.
- R9: For a memory-window hit, rsp_prefetch equals base bit 3 of the window that answered.
- R10: The response appears exactly one cycle after req_valid. In a cycle with no request, all response outputs are 0.
- R11: A register write and a request in the same cycle: the request is translated with the old register values. A request in the next cycle sees the new values.
- R12: Size codes 12 to 15 act as code 11 (2 GB). A window whose base bit 0 is 0 never matches, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CAW | Register select {window index, is_map} |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local-bus address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | An enabled window covered the address |
| rsp_addr | output | 32 | Translated PCI address |
| rsp_ctype | output | 3 | PCI cycle type |
| rsp_win | output | WSEL | Index of the window that answered |
| rsp_prefetch | output | 1 | Prefetch flag of the window that answered |

## Verification
The bench builds the block with NUM_MEM_WIN set to 3, not the default 2. This gives three memory windows that can all overlap, so first-match order is tested across more than one pair. It also places the I/O window at index 3, where the select field is fully used and the priority loop runs one step further than in the default build. A behavioural model works out window coverage with range arithmetic. It is run against directed overlap, disable, size-saturation and same-cycle write cases, and then against a long run of random register rewrites mixed with requests.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;

  localparam int ADDR_W       = 32;
  localparam int PAGE_LSB     = 20;  // memory window granule: 1 MB
  localparam int PAGE_BITS    = ADDR_W - PAGE_LSB;
  localparam int IO_LSB       = 24;  // I/O window granule: 16 MB
  localparam int IO_BITS      = ADDR_W - IO_LSB;
  localparam int MAX_SIZE_CODE = 11;
  localparam int MAP_W        = 16;

  // Bits of a memory base word that are kept: address, swap, size, prefetch, enable
  localparam logic [ADDR_W-1:0] MEM_BASE_KEEP = 32'hFFF0_03F9;
  localparam logic [MAP_W-1:0]  IO_BASE_KEEP  = 16'hFF01;
  localparam logic [MAP_W-1:0]  IO_MAP_KEEP   = 16'hFF00;

  typedef enum logic [2:0] {
    CYC_IACK  = 3'b000,
    CYC_IO    = 3'b001,
    CYC_MEM   = 3'b011,
    CYC_CFG   = 3'b101,
    CYC_MEMML = 3'b110
  } cyc_type_e;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        ctype;
    logic              prefetch;
  } win_result_t;

endpackage

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs
  import addr_xlat_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  parameter int CAW         = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [CAW-1:0]                       cfg_addr,
  input  logic [ADDR_W-1:0]                    cfg_wdata,
  output logic [NUM_MEM_WIN-1:0][ADDR_W-1:0]   mem_base,
  output logic [NUM_MEM_WIN-1:0][MAP_W-1:0]    mem_map,
  output logic [MAP_W-1:0]                     io_base,
  output logic [MAP_W-1:0]                     io_map
);

  localparam int IO_IDX = NUM_MEM_WIN;

  logic [NUM_MEM_WIN-1:0] base_wr;
  logic [NUM_MEM_WIN-1:0] map_wr;
  logic                   io_base_wr;
  logic                   io_map_wr;

  logic [ADDR_W-1:0] base_wdata;
  logic [MAP_W-1:0]  map_wdata;
  logic [MAP_W-1:0]  io_base_wdata;
  logic [MAP_W-1:0]  io_map_wdata;

  // Write decode and next-state data
  always_comb begin
    for (int i = 0; i < NUM_MEM_WIN; i++) begin
      base_wr[i] = cfg_we && (cfg_addr == CAW'(2 * i));
      map_wr[i]  = cfg_we && (cfg_addr == CAW'(2 * i + 1));
    end
    io_base_wr    = cfg_we && (cfg_addr == CAW'(2 * IO_IDX));
    io_map_wr     = cfg_we && (cfg_addr == CAW'(2 * IO_IDX + 1));
    base_wdata    = cfg_wdata & MEM_BASE_KEEP;
    map_wdata     = cfg_wdata[MAP_W-1:0];
    io_base_wdata = cfg_wdata[MAP_W-1:0] & IO_BASE_KEEP;
    io_map_wdata  = cfg_wdata[MAP_W-1:0] & IO_MAP_KEEP;
  end

  generate
    for (genvar g = 0; g < NUM_MEM_WIN; g++) begin : g_mem
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_base[g] <= '0;
        end else if (base_wr[g]) begin
          mem_base[g] <= base_wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_map[g] <= '0;
        end else if (map_wr[g]) begin
          mem_map[g] <= map_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_base <= '0;
    end else if (io_base_wr) begin
      io_base <= io_base_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_map <= '0;
    end else if (io_map_wr) begin
      io_map <= io_map_wdata;
    end
  end

endmodule

// File: rtl/xlat_mem_window.sv
module xlat_mem_window
  import addr_xlat_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [MAP_W-1:0]  map,
  input  logic [ADDR_W-1:0] addr,
  output win_result_t       res
);

  logic [3:0]           size_code;
  logic [PAGE_BITS-1:0] cmp_mask;
  logic [PAGE_BITS-1:0] page_hi;
  logic [1:0]           low_bits;
  logic                 unused_fields;

  assign unused_fields = ^{base[19:10], base[9:8], base[2:1]};

  always_comb begin
    // Codes beyond the largest size saturate to it
    size_code = (base[7:4] > 4'(MAX_SIZE_CODE)) ? 4'(MAX_SIZE_CODE) : base[7:4];
    cmp_mask  = {PAGE_BITS{1'b1}} << size_code;
    page_hi   = (map[15:4] & cmp_mask) | (addr[ADDR_W-1:PAGE_LSB] & ~cmp_mask);
    low_bits  = map[0] ? addr[1:0] : 2'b00;

    res.hit      = base[0] &&
                   (((addr[ADDR_W-1:PAGE_LSB] ^ base[ADDR_W-1:PAGE_LSB]) & cmp_mask) == '0);
    res.addr     = {page_hi, addr[PAGE_LSB-1:2], low_bits};
    res.ctype    = map[3:1];
    res.prefetch = base[3];
  end

endmodule

// File: rtl/xlat_io_window.sv
module xlat_io_window
  import addr_xlat_pkg::*;
(
  input  logic [MAP_W-1:0]  base,
  input  logic [MAP_W-1:0]  map,
  input  logic [ADDR_W-1:0] addr,
  output win_result_t       res
);

  logic unused_fields;

  assign unused_fields = ^{base[7:1], map[7:0]};

  always_comb begin
    res.hit      = base[0] && (addr[ADDR_W-1:IO_LSB] == base[15:8]);
    res.addr     = {map[15:8], addr[IO_LSB-1:0]};
    res.ctype    = CYC_IO;
    res.prefetch = 1'b0;
  end

endmodule

// File: rtl/xlat_prio_pick.sv
module xlat_prio_pick
  import addr_xlat_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int WSEL    = 2
) (
  input  win_result_t [NUM_WIN-1:0] cand,
  output win_result_t               pick,
  output logic [WSEL-1:0]           pick_idx
);

  // Walk from the highest index down so that the lowest matching index is left
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (cand[i].hit) begin
        pick     = cand[i];
        pick_idx = WSEL'(i);
      end
    end
  end

endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
  import addr_xlat_pkg::*;
#(
  parameter int  NUM_MEM_WIN = 2,
  localparam int NUM_WIN     = NUM_MEM_WIN + 1,
  localparam int WSEL        = $clog2(NUM_WIN),
  localparam int CAW         = WSEL + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CAW-1:0]    cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_addr,
  output logic [2:0]        rsp_ctype,
  output logic [WSEL-1:0]   rsp_win,
  output logic              rsp_prefetch
);

  logic [NUM_MEM_WIN-1:0][ADDR_W-1:0] mem_base;
  logic [NUM_MEM_WIN-1:0][MAP_W-1:0]  mem_map;
  logic [MAP_W-1:0]                   io_base;
  logic [MAP_W-1:0]                   io_map;

  win_result_t [NUM_WIN-1:0] cand;
  win_result_t               pick;
  logic [WSEL-1:0]           pick_idx;

  logic            valid_d;
  logic            hit_d;
  logic [31:0]     addr_d;
  logic [2:0]      ctype_d;
  logic [WSEL-1:0] win_d;
  logic            pf_d;

  xlat_cfg_regs #(
    .NUM_MEM_WIN (NUM_MEM_WIN),
    .CAW         (CAW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mem_base  (mem_base),
    .mem_map   (mem_map),
    .io_base   (io_base),
    .io_map    (io_map)
  );

  generate
    for (genvar g = 0; g < NUM_MEM_WIN; g++) begin : g_win
      xlat_mem_window u_win (
        .base (mem_base[g]),
        .map  (mem_map[g]),
        .addr (req_addr),
        .res  (cand[g])
      );
    end
  endgenerate

  xlat_io_window u_io (
    .base (io_base),
    .map  (io_map),
    .addr (req_addr),
    .res  (cand[NUM_MEM_WIN])
  );

  xlat_prio_pick #(
    .NUM_WIN (NUM_WIN),
    .WSEL    (WSEL)
  ) u_pick (
    .cand     (cand),
    .pick     (pick),
    .pick_idx (pick_idx)
  );

  // Response next state: zeros unless a request hit
  always_comb begin
    valid_d = req_valid;
    hit_d   = 1'b0;
    addr_d  = '0;
    ctype_d = '0;
    win_d   = '0;
    pf_d    = 1'b0;
    if (req_valid && pick.hit) begin
      hit_d   = 1'b1;
      addr_d  = pick.addr;
      ctype_d = pick.ctype;
      win_d   = pick_idx;
      pf_d    = pick.prefetch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_addr     <= '0;
      rsp_ctype    <= '0;
      rsp_win      <= '0;
      rsp_prefetch <= 1'b0;
    end else begin
      rsp_valid    <= valid_d;
      rsp_hit      <= hit_d;
      rsp_addr     <= addr_d;
      rsp_ctype    <= ctype_d;
      rsp_win      <= win_d;
      rsp_prefetch <= pf_d;
    end
  end

endmodule

// File: rtl/addr_window_xlat_chk.sv
module addr_window_xlat_chk #(
  parameter int NUM_MEM_WIN = 2,
  parameter int WSEL        = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [31:0]     req_addr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [31:0]     rsp_addr,
  input logic [2:0]      rsp_ctype,
  input logic [WSEL-1:0] rsp_win,
  input logic            rsp_prefetch
);

  // R10
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && rsp_addr == '0));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_ctype == '0 &&
                                  rsp_win == '0 && !rsp_prefetch));

  // R3
  mid_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_addr[19:2] == $past(req_addr[19:2])));

  // R7
  io_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && rsp_win == WSEL'(NUM_MEM_WIN)) |-> (rsp_ctype == 3'b001 && !rsp_prefetch));

  // R7
  io_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!(rsp_hit && rsp_win == WSEL'(NUM_MEM_WIN)) ||
                   rsp_addr[23:0] == $past(req_addr[23:0])));

  // R6
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && rsp_win <= WSEL'(NUM_MEM_WIN)));

endmodule

bind addr_window_xlat addr_window_xlat_chk #(
  .NUM_MEM_WIN (NUM_MEM_WIN),
  .WSEL        (WSEL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_addr     (rsp_addr),
  .rsp_ctype    (rsp_ctype),
  .rsp_win      (rsp_win),
  .rsp_prefetch (rsp_prefetch)
);

// File: tb/addr_window_xlat_bench.sv
module addr_window_xlat_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NMW  = 3;
  localparam int WSEL = $clog2(NMW + 1);
  localparam int CAW  = WSEL + 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we;
  logic [CAW-1:0]  cfg_addr;
  logic [31:0]     cfg_wdata;
  logic            req_valid;
  logic [31:0]     req_addr;
  logic            rsp_valid;
  logic            rsp_hit;
  logic [31:0]     rsp_addr;
  logic [2:0]      rsp_ctype;
  logic [WSEL-1:0] rsp_win;
  logic            rsp_prefetch;

  int vectors = 0;
  int miscompares = 0;

  // Behavioural model state
  logic [31:0] m_base [NMW];
  logic [15:0] m_map  [NMW];
  logic [15:0] m_iob;
  logic [15:0] m_iom;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_window_xlat #(.NUM_MEM_WIN(NMW)) u_addr_window_xlat (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_addr     (rsp_addr),
    .rsp_ctype    (rsp_ctype),
    .rsp_win      (rsp_win),
    .rsp_prefetch (rsp_prefetch)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  // Range-based model of coverage and translation
  function automatic void model(input logic [31:0] a, output bit h, output logic [31:0] pa,
                                output logic [2:0] ct, output int w, output bit pf);
    h = 0; pa = '0; ct = '0; w = 0; pf = 0;
    for (int i = 0; i < NMW; i++) begin
      if (!h && m_base[i][0]) begin
        longint code = longint'(m_base[i][7:4]);
        longint size, lo, amask;
        if (code > 11) code = 11;
        size  = longint'(1) << (20 + code);
        amask = size - 1;
        lo    = longint'({m_base[i][31:20], 20'h0}) & ~amask;
        if (longint'(a) >= lo && longint'(a) < lo + size) begin
          longint hi = longint'({m_map[i][15:4], 20'h0}) & ~amask;
          h  = 1;
          pa = 32'(hi | (longint'(a) & amask));
          if (!m_map[i][0]) pa[1:0] = 2'b00;
          ct = m_map[i][3:1];
          w  = i;
          pf = m_base[i][3];
        end
      end
    end
    if (!h && m_iob[0] && a[31:24] == m_iob[15:8]) begin
      h = 1; pa = {m_iom[15:8], a[23:0]}; ct = 3'b001; w = NMW; pf = 0;
    end
  endfunction

  task automatic model_write(input logic [CAW-1:0] ca, input logic [31:0] cd);
    int idx = int'(ca >> 1);
    if (idx < NMW) begin
      if (ca[0]) m_map[idx] = cd[15:0];
      else       m_base[idx] = cd;
    end else if (idx == NMW) begin
      if (ca[0]) m_iom = cd[15:0];
      else       m_iob = cd[15:0];
    end
  endtask

  // One clock: drive, predict from old state, update model, compare after the edge
  task automatic cyc(input bit we, input logic [CAW-1:0] ca, input logic [31:0] cd,
                     input bit rv, input logic [31:0] ra, input string tag);
    bit h, pf; logic [31:0] pa; logic [2:0] ct; int w;
    logic [38+WSEL-1:0] exp_v, act_v;
    cfg_we = we; cfg_addr = ca; cfg_wdata = cd; req_valid = rv; req_addr = ra;
    model(ra, h, pa, ct, w, pf);
    if (!rv) begin h = 0; pa = '0; ct = '0; w = 0; pf = 0; end
    if (we) model_write(ca, cd);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    exp_v = {rv, h, pa, ct, WSEL'(w), pf};
    act_v = {rsp_valid, rsp_hit, rsp_addr, rsp_ctype, rsp_win, rsp_prefetch};
    vectors++;
    if (act_v !== exp_v) begin
      miscompares++;
      $display("FAIL %s: req %h actual v=%b h=%b a=%h t=%b w=%0d p=%b expected v=%b h=%b a=%h t=%b w=%0d p=%b",
               tag, ra, rsp_valid, rsp_hit, rsp_addr, rsp_ctype, rsp_win, rsp_prefetch,
               rv, h, pa, ct, w, pf);
    end
  endtask

  task automatic wr(input logic [CAW-1:0] ca, input logic [31:0] cd, input string tag);
    cyc(1'b1, ca, cd, 1'b0, 32'h0, tag);
  endtask

  task automatic rq(input logic [31:0] ra, input string tag);
    cyc(1'b0, '0, 32'h0, 1'b1, ra, tag);
  endtask

  initial begin
    for (int i = 0; i < NMW; i++) begin m_base[i] = '0; m_map[i] = '0; end
    m_iob = '0; m_iom = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: rsp_valid in reset actual %b expected 0", rsp_valid);
    end
    rst_n = 1'b1;

    // R1 R8: nothing enabled
    rq(32'h4000_0000, "R1");
    rq(32'hFFFF_FFFF, "R8");
    cyc(1'b0, '0, 32'h0, 1'b0, 32'h1234_5678, "R10");

    // R2 R3 R4 R5: window 0, 256 MB, memory cycle, low bits forced to zero
    wr(3'd0, 32'h4000_0081, "R2");
    wr(3'd1, 32'h0000_8006, "R4");
    rq(32'h4123_4567, "R3");
    rq(32'h3FFF_FFFF, "R2");
    rq(32'h4FFF_FFFF, "R2");
    rq(32'h5000_0000, "R2");

    // R9 R5: window 1 prefetchable, low bits passed
    wr(3'd2, 32'h5000_0089, "R9");
    wr(3'd3, 32'h0000_9007, "R5");
    rq(32'h5ABC_DEF3, "R9");
    rq(32'h5000_0002, "R5");

    // R7: I/O window
    wr(3'd6, 32'h0000_6001, "R7");
    wr(3'd7, 32'h0000_1200, "R7");
    rq(32'h6055_AA03, "R7");
    rq(32'h6155_AA03, "R7");

    // R11 R6: widen window 0 to 512 MB while translating
    cyc(1'b1, 3'd0, 32'h4000_0091, 1'b1, 32'h5ABC_DEF3, "R11");
    rq(32'h5ABC_DEF3, "R6");

    // R6 R4: window 2 configuration cycle over the I/O region
    wr(3'd4, 32'h6000_0041, "R6");
    wr(3'd5, 32'h0000_000A, "R4");
    rq(32'h6055_AA03, "R6");
    wr(3'd5, 32'h0000_0000, "R4");
    rq(32'h6000_0107, "R4");
    wr(3'd5, 32'h0000_000D, "R4");
    rq(32'h6000_0107, "R4");
    wr(3'd4, 32'h6000_0040, "R12");
    rq(32'h6055_AA03, "R12");

    // R12: disabled window 0 then size saturation
    wr(3'd0, 32'h4000_0090, "R12");
    rq(32'h4123_4567, "R12");
    wr(3'd2, 32'h0000_00E1, "R12");
    rq(32'h7FFF_FFFC, "R12");
    rq(32'h8000_0000, "R12");
    wr(3'd2, 32'h0000_0000, "R12");
    rq(32'h7FFF_FFFC, "R8");

    // Random sweep: rewrites mixed with requests
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] d = $urandom;
      bit we = ($urandom % 4) == 0;
      logic [CAW-1:0] ca = CAW'($urandom);
      a[31:28] = 4'(4 + ($urandom % 4));
      if (!ca[0]) d[31:28] = 4'(4 + ($urandom % 4));
      if (ca == 3'd6) d[15:12] = 4'(4 + ($urandom % 4));
      cyc(we, ca, d, ($urandom % 5) != 0, a, "R6");
    end

    finish_run();
  end

endmodule